// File: doc/BRIEF.md
# Bathtub phase-increment profile generator

This block shapes the horizontal resampling ratio along one video line. For every output sample it supplies a signed phase increment that sets how fast the input stream is walked. The increment runs from -128, where two output samples are made per input sample, through 0, where the rate is unchanged, up to 255, where close to two input samples are consumed per output sample. That gives 384 ratio steps between 2 and 0.5. Along the line the increment follows a bathtub-like curve built from five areas. These are an outer and an inner area on each side and a flat centre.

Four programmed 8-bit boundaries are compared against the output sample position. The position is the count of output samples since the line strobe, divided by 4. In the centre the increment is a constant: the 8-bit centre code with the zoom bit added as its sign. In the inner and outer areas a double integrator bends the curve. A slope register adds the area's 6-bit second-difference coefficient, and then the increment adds the new slope. A phase accumulator with 8 fractional bits turns each increment into the number of input samples that the downstream interpolator must take for that output sample. The line ends after 4 x (line code + 1) output samples. A hold option carries the curve state from one line into the next.

Top module: `bt_dto_profile`

## Requirements
- R1: After reset, `dto_inc_o` is 0, `area_o` is 0 and `take_o` is 0.
- R2: A sample is accepted when `sample_adv_i` is high, the line is active and `line_start_i` is low. Its position p is the number of samples accepted since the last line strobe, divided by 4. Its area is taken in this order: p < `x1l_i` gives 4 (left outer); otherwise p < `x0l_i` gives 5 (left inner); otherwise p < `x0r_i` gives 1 (centre); otherwise p < `x1r_i` gives 2 (right inner); otherwise 3 (right outer). `area_o` shows this code from the next cycle on.
- R3: For a centre sample, the increment becomes {`zoom_i`,`c0_i`} read as a 9-bit two's complement value, raised to -128 if it is lower, and the slope becomes 0.
- R4: For any other sample, the slope becomes slope + coefficient, then the increment becomes increment + new slope. The coefficient is `c1_i` in the inner areas (2, 5) and `c2_i` in the outer areas (3, 4), each a 6-bit two's complement value.
- R5: The increment is held within -128..255 and the slope within -512..511, saturating at these limits.
- R6: For each accepted sample, s = phase + 256 + new increment. `take_o` equals s / 256 for one cycle, the phase keeps s mod 256, and `take_o` is 0 in every cycle without an accepted sample.
- R7: After 4 x (`spl_i` + 1) accepted samples the line is inactive. A further `sample_adv_i` then leaves `dto_inc_o` and `area_o` unchanged and gives `take_o` = 0. Before the first line strobe the line is also inactive.
- R8: `line_start_i` clears the sample count and the phase, and sets `area_o` and `take_o` to 0. With `keep_i` low it also loads the R3 centre value into the increment and clears the slope.
- R9: With `keep_i` high, `line_start_i` leaves the increment and the slope as the previous line left them.
- R10: `line_start_i` takes priority over a `sample_adv_i` in the same cycle; that sample is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start_i | input | 1 | Line strobe |
| sample_adv_i | input | 1 | One output sample is produced |
| keep_i | input | 1 | Carry curve state across the line strobe |
| zoom_i | input | 1 | Sign bit of the centre increment |
| c0_i | input | 8 | Centre increment code |
| c1_i | input | 6 | Inner-area second difference, two's complement |
| c2_i | input | 6 | Outer-area second difference, two's complement |
| x1l_i | input | 8 | Left outer/inner boundary, units of 4 samples |
| x0l_i | input | 8 | Left inner/centre boundary |
| x0r_i | input | 8 | Centre/right inner boundary |
| x1r_i | input | 8 | Right inner/outer boundary |
| spl_i | input | 8 | Line length code, 4 x (code + 1) samples |
| dto_inc_o | output | 9 | Current signed phase increment |
| area_o | output | 3 | Area code of the last accepted sample |
| take_o | output | 2 | Input samples consumed by the last accepted sample |

## Verification
The main function is first driven with directed lines that sit wholly in one area. A flat centre line in compress and in zoom separates the zoom sign handling and the phase carry pattern (0/1 alternation at -128). A line wholly in the left outer area, with the largest positive and negative coefficients, separates the integrator order and the two saturation limits. Random lines then use sorted random boundaries, random coefficients, random line lengths, gaps between samples, and random hold settings. These tell apart the area priority, the inner/outer coefficient choice and the phase remainder carried between samples. Directed cases cover samples past the line end, a strobe together with a sample, and a strobe with hold set.

// File: rtl/bt_pkg.sv
// Shared types for the bathtub increment profile generator.
package bt_pkg;

    // Area code of one output sample; 0 means no sample yet in this line.
    typedef enum logic [2:0] {
        AREA_NONE  = 3'd0,
        AREA_MID   = 3'd1,
        AREA_R_IN  = 3'd2,
        AREA_R_OUT = 3'd3,
        AREA_L_OUT = 3'd4,
        AREA_L_IN  = 3'd5
    } area_e;

endpackage

// File: rtl/bt_area_decode.sv
// Maps a sample position to its curve area.
// Assumes the boundaries are in the same units as pos_i (4 samples each);
// the comparisons run in a fixed priority, so unordered boundaries still
// give a defined result.
module bt_area_decode
    import bt_pkg::*;
#(
    parameter int POS_W = 8
) (
    input  logic [POS_W-1:0] pos_i,
    input  logic [POS_W-1:0] x1l_i,
    input  logic [POS_W-1:0] x0l_i,
    input  logic [POS_W-1:0] x0r_i,
    input  logic [POS_W-1:0] x1r_i,
    output area_e            area_o
);

    // Priority compare from the left edge towards the right edge.
    always_comb begin
        if (pos_i < x1l_i) begin
            area_o = AREA_L_OUT;
        end else if (pos_i < x0l_i) begin
            area_o = AREA_L_IN;
        end else if (pos_i < x0r_i) begin
            area_o = AREA_MID;
        end else if (pos_i < x1r_i) begin
            area_o = AREA_R_IN;
        end else begin
            area_o = AREA_R_OUT;
        end
    end

endmodule

// File: rtl/bt_curve_integrator.sv
// Double integrator that produces the phase increment.
// Assumes load_i and step_i are never both acted on (load wins).
// The increment is kept in -(2^(C0_W-1)) .. 2^C0_W-1 and the slope in its
// own signed range, both by saturation.
module bt_curve_integrator #(
    parameter int C0_W = 8,
    parameter int CK_W = 6,
    parameter int SL_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     step_i,
    input  logic                     centre_i,
    input  logic                     outer_i,
    input  logic                     zoom_i,
    input  logic [C0_W-1:0]          c0_i,
    input  logic signed [CK_W-1:0]   c1_i,
    input  logic signed [CK_W-1:0]   c2_i,
    output logic signed [C0_W:0]     inc_next_o,
    output logic signed [C0_W:0]     inc_o
);

    localparam int INC_W = C0_W + 1;
    localparam int SUM_W = ((SL_W > INC_W) ? SL_W : INC_W) + 2;
    localparam logic signed [SUM_W-1:0] INC_HI = SUM_W'((1 << C0_W) - 1);
    localparam logic signed [SUM_W-1:0] INC_LO = SUM_W'(-(1 << (C0_W - 1)));
    localparam logic signed [SUM_W-1:0] SL_HI  = SUM_W'((1 << (SL_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] SL_LO  = SUM_W'(-(1 << (SL_W - 1)));

    logic signed [SL_W-1:0]  slope_r;
    logic signed [INC_W-1:0] inc_r;
    logic signed [CK_W-1:0]  coef;
    logic signed [INC_W-1:0] c0_full;
    logic signed [SUM_W-1:0] c0_sat;
    logic signed [SUM_W-1:0] slope_sum;
    logic signed [SUM_W-1:0] slope_sat;
    logic signed [SL_W-1:0]  slope_next;
    logic signed [SUM_W-1:0] inc_sum;
    logic signed [SUM_W-1:0] inc_sat;
    logic signed [INC_W-1:0] inc_next;

    // Clamp a wide signed value into [lo, hi].
    function automatic logic signed [SUM_W-1:0] clamp(
        input logic signed [SUM_W-1:0] v,
        input logic signed [SUM_W-1:0] lo,
        input logic signed [SUM_W-1:0] hi
    );
        if (v < lo) begin
            return lo;
        end else if (v > hi) begin
            return hi;
        end
        return v;
    endfunction

    // Centre constant: zoom bit acts as the sign, raised to the lower limit.
    always_comb begin
        c0_full = $signed({zoom_i, c0_i});
        c0_sat  = clamp(SUM_W'(c0_full), INC_LO, INC_HI);
    end

    // Next slope and increment for one output sample.
    always_comb begin
        coef       = outer_i ? c2_i : c1_i;
        slope_sum  = SUM_W'(slope_r) + SUM_W'(coef);
        slope_sat  = clamp(slope_sum, SL_LO, SL_HI);
        slope_next = centre_i ? '0 : slope_sat[SL_W-1:0];
        inc_sum    = SUM_W'(inc_r) + SUM_W'(slope_next);
        inc_sat    = clamp(inc_sum, INC_LO, INC_HI);
        inc_next   = centre_i ? c0_sat[INC_W-1:0] : inc_sat[INC_W-1:0];
    end

    // Integrator state: reset, line load, or one sample step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slope_r <= '0;
            inc_r   <= '0;
        end else if (load_i) begin
            slope_r <= '0;
            inc_r   <= c0_sat[INC_W-1:0];
        end else if (step_i) begin
            slope_r <= slope_next;
            inc_r   <= inc_next;
        end
    end

    assign inc_next_o = inc_next;
    assign inc_o      = inc_r;

    AST_INC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (SUM_W'(inc_r) >= INC_LO) && (SUM_W'(inc_r) <= INC_HI)); // R5

    AST_MID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !load_i && centre_i && !zoom_i
        |=> inc_r == $past($signed({1'b0, c0_i}))); // R3

    AST_MID_SLOPE: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !load_i && centre_i |=> slope_r == '0); // R3

endmodule

// File: rtl/bt_phase_accum.sv
// Fractional phase accumulator: per accepted sample it adds one unit plus
// the signed increment and reports the whole input samples crossed.
// Assumes the increment lies in -(2^(FR_W-1)) .. 2^FR_W-1, so at most two
// input samples are crossed per step.
module bt_phase_accum #(
    parameter int FR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  step_i,
    input  logic signed [FR_W:0]  inc_i,
    output logic [1:0]            take_o
);

    logic [FR_W-1:0] acc_r;
    logic [FR_W+1:0] sum;

    // Phase plus one unit plus the sign-extended increment.
    always_comb begin
        sum = {2'b00, acc_r} + (FR_W + 2)'(1 << FR_W) + {inc_i[FR_W], inc_i};
    end

    // Keep the remainder; the take count lives for one cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_r  <= '0;
            take_o <= '0;
        end else if (clr_i) begin
            acc_r  <= '0;
            take_o <= '0;
        end else if (step_i) begin
            acc_r  <= sum[FR_W-1:0];
            take_o <= sum[FR_W+1:FR_W];
        end else begin
            take_o <= '0;
        end
    end

    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o != 2'd0 |-> $past(step_i) && !$past(clr_i)); // R6

    AST_TAKE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        take_o != 2'd3); // R6

    AST_PHASE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> acc_r == '0); // R8

endmodule

// File: rtl/bt_dto_profile.sv
// Top of the bathtub increment profile generator.
// Counts output samples since the line strobe, decodes the area from the
// count divided by 4, steps the integrator and the phase accumulator once
// per accepted sample and stops after 4*(spl_i+1) samples.
// Assumes all programming inputs are stable during a line.
module bt_dto_profile
    import bt_pkg::*;
#(
    parameter int POS_W = 8,
    parameter int C0_W  = 8,
    parameter int CK_W  = 6,
    parameter int SL_W  = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_start_i,
    input  logic                  sample_adv_i,
    input  logic                  keep_i,
    input  logic                  zoom_i,
    input  logic [C0_W-1:0]       c0_i,
    input  logic [CK_W-1:0]       c1_i,
    input  logic [CK_W-1:0]       c2_i,
    input  logic [POS_W-1:0]      x1l_i,
    input  logic [POS_W-1:0]      x0l_i,
    input  logic [POS_W-1:0]      x0r_i,
    input  logic [POS_W-1:0]      x1r_i,
    input  logic [POS_W-1:0]      spl_i,
    output logic signed [C0_W:0]  dto_inc_o,
    output logic [2:0]            area_o,
    output logic [1:0]            take_o
);

    localparam int CNT_W = POS_W + 2;

    logic [CNT_W-1:0]     cnt_r;
    logic                 active_r;
    area_e                area_r;
    area_e                area_now;
    logic [POS_W-1:0]     pos;
    logic                 step;
    logic                 load;
    logic                 is_mid;
    logic                 is_outer;
    logic                 last;
    logic signed [C0_W:0] inc_next;

    // Position and per-cycle controls.
    always_comb begin
        pos      = cnt_r[CNT_W-1:2];
        step     = sample_adv_i && active_r && !line_start_i;
        load     = line_start_i && !keep_i;
        last     = (cnt_r == {spl_i, 2'b11});
        is_mid   = (area_now == AREA_MID);
        is_outer = (area_now == AREA_L_OUT) || (area_now == AREA_R_OUT);
    end

    bt_area_decode #(
        .POS_W (POS_W)
    ) u_area (
        .pos_i  (pos),
        .x1l_i  (x1l_i),
        .x0l_i  (x0l_i),
        .x0r_i  (x0r_i),
        .x1r_i  (x1r_i),
        .area_o (area_now)
    );

    bt_curve_integrator #(
        .C0_W (C0_W),
        .CK_W (CK_W),
        .SL_W (SL_W)
    ) u_curve (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .step_i     (step),
        .centre_i   (is_mid),
        .outer_i    (is_outer),
        .zoom_i     (zoom_i),
        .c0_i       (c0_i),
        .c1_i       ($signed(c1_i)),
        .c2_i       ($signed(c2_i)),
        .inc_next_o (inc_next),
        .inc_o      (dto_inc_o)
    );

    bt_phase_accum #(
        .FR_W (C0_W)
    ) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (line_start_i),
        .step_i (step),
        .inc_i  (inc_next),
        .take_o (take_o)
    );

    // Sample counter, line activity and area of the last accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_r    <= '0;
            active_r <= 1'b0;
            area_r   <= AREA_NONE;
        end else if (line_start_i) begin
            cnt_r    <= '0;
            active_r <= 1'b1;
            area_r   <= AREA_NONE;
        end else if (step) begin
            cnt_r    <= cnt_r + CNT_W'(1);
            area_r   <= area_now;
            if (last) begin
                active_r <= 1'b0;
            end
        end
    end

    assign area_o = area_r;

    AST_LEFT_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
        step && (pos < x1l_i) |=> area_o == 3'd4); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sample_adv_i && !active_r && !line_start_i
        |=> $stable(dto_inc_o) && $stable(area_o) && take_o == 2'd0); // R7

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_i |=> area_o == 3'd0 && take_o == 2'd0 && cnt_r == '0); // R10

    AST_KEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_i && keep_i |=> $stable(dto_inc_o)); // R9

endmodule

// File: tb/sim_bt_dto_profile.sv
// Self-checking bench: directed corner lines plus seeded random lines,
// compared against a behavioural model written from the requirements.
module sim_bt_dto_profile;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_start = 1'b0;
    logic              adv = 1'b0;
    logic              keep = 1'b0;
    logic              zoom = 1'b0;
    logic [7:0]        c0 = '0;
    logic [5:0]        c1 = '0;
    logic [5:0]        c2 = '0;
    logic [7:0]        x1l = '0, x0l = '0, x0r = '0, x1r = '0, spl = '0;
    logic signed [8:0] inc_o;
    logic [2:0]        area_o;
    logic [1:0]        take_o;

    int n_chk = 0;
    int n_bad = 0;

    // Model state.
    int m_inc = 0, m_slope = 0, m_phase = 0, m_cnt = 0, m_area = 0, m_take = 0;
    bit m_active = 1'b0;

    always #4 clk = ~clk;

    bt_dto_profile u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start),
        .sample_adv_i (adv),
        .keep_i       (keep),
        .zoom_i       (zoom),
        .c0_i         (c0),
        .c1_i         (c1),
        .c2_i         (c2),
        .x1l_i        (x1l),
        .x0l_i        (x0l),
        .x0r_i        (x0r),
        .x1r_i        (x1r),
        .spl_i        (spl),
        .dto_inc_o    (inc_o),
        .area_o       (area_o),
        .take_o       (take_o)
    );

    function automatic int clampi(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int s6(logic [5:0] v);
        return v[5] ? int'(v) - 64 : int'(v);
    endfunction

    function automatic int mid_val();
        return clampi(zoom ? int'(c0) - 256 : int'(c0), -128, 255);
    endfunction

    function automatic int area_of(int p);
        if (p < x1l) return 4;
        if (p < x0l) return 5;
        if (p < x0r) return 1;
        if (p < x1r) return 2;
        return 3;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Model update for one clock with the given strobes.
    task automatic model_step(bit ls, bit ad);
        if (ls) begin
            m_cnt = 0; m_active = 1'b1; m_phase = 0; m_area = 0; m_take = 0;
            if (!keep) begin
                m_inc = mid_val();
                m_slope = 0;
            end
        end else if (ad && m_active) begin
            int s;
            m_area = area_of(m_cnt / 4);
            if (m_area == 1) begin
                m_slope = 0;
                m_inc = mid_val();
            end else begin
                m_slope = clampi(m_slope + ((m_area == 2 || m_area == 5) ? s6(c1) : s6(c2)), -512, 511);
                m_inc = clampi(m_inc + m_slope, -128, 255);
            end
            s = m_phase + 256 + m_inc;
            m_take = s / 256;
            m_phase = s % 256;
            m_cnt++;
            if (m_cnt == 4 * (int'(spl) + 1)) m_active = 1'b0;
        end else begin
            m_take = 0;
        end
    endtask

    // One clock: drive at the falling edge, check at the next falling edge.
    task automatic cycle(bit ls, bit ad, string tag);
        line_start = ls;
        adv = ad;
        @(posedge clk);
        model_step(ls, ad);
        @(negedge clk);
        line_start = 1'b0;
        adv = 1'b0;
        chk(tag, "dto_inc", int'(inc_o), m_inc);
        chk(tag, "area", int'(area_o), m_area);
        chk(tag, "take", int'(take_o), m_take);
    endtask

    task automatic run_line(int gaps, string tag);
        cycle(1'b1, 1'b0, tag);
        while (m_active) begin
            cycle(1'b0, 1'b1, tag);
            if (gaps != 0 && ($urandom % 4) == 0) cycle(1'b0, 1'b0, tag);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk("R1", "dto_inc", int'(inc_o), 0);
        chk("R1", "area", int'(area_o), 0);
        chk("R1", "take", int'(take_o), 0);
        // R7: samples before any line strobe are ignored.
        cycle(1'b0, 1'b1, "R7");
        cycle(1'b0, 1'b1, "R7");

        // R3 R6: flat centre line, compress.
        x1l = 0; x0l = 0; x0r = 8'hff; x1r = 8'hff; spl = 3;
        zoom = 0; c0 = 64; c1 = 6'd5; c2 = 6'd9;
        run_line(0, "R3 R6");
        // R3 R6: zoom by two, take alternates 0/1.
        zoom = 1; c0 = 128;
        run_line(1, "R3 R6");
        // R5: centre code below the lower limit.
        c0 = 0;
        run_line(0, "R5");

        // R4 R5: whole line in the left outer area, ramp to the limits.
        x1l = 8'hff; zoom = 0; c0 = 0; c2 = 6'h1f; spl = 15;
        run_line(0, "R4 R5");
        c2 = 6'h20;
        run_line(0, "R4 R5");

        // R7: samples past the line end.
        repeat (3) cycle(1'b0, 1'b1, "R7");

        // R9: strobe with hold keeps the increment and slope.
        keep = 1; c2 = 6'h01;
        cycle(1'b1, 1'b0, "R9");
        repeat (6) cycle(1'b0, 1'b1, "R9");
        keep = 0;

        // R10: strobe together with a sample mid-line.
        cycle(1'b1, 1'b1, "R10 R8");
        repeat (5) cycle(1'b0, 1'b1, "R10");
        cycle(1'b1, 1'b1, "R10 R8");
        cycle(1'b0, 1'b1, "R10");

        // R2 R4 R6 R8 R9: random lines.
        for (int ln = 0; ln < 40; ln++) begin
            int b[4];
            for (int i = 0; i < 4; i++) b[i] = $urandom % 256;
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3 - i; j++)
                    if (b[j] > b[j+1]) begin
                        int t = b[j]; b[j] = b[j+1]; b[j+1] = t;
                    end
            x1l = 8'(b[0]); x0l = 8'(b[1]); x0r = 8'(b[2]); x1r = 8'(b[3]);
            spl = 8'($urandom);
            c0 = 8'($urandom); zoom = 1'($urandom);
            c1 = 6'($urandom); c2 = 6'($urandom);
            keep = (($urandom % 5) == 0);
            run_line(1, "R2 R4 R6 R8");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule